// File: doc/BRIEF.md
# Compound-Adder Significand Rounder

This block adds two aligned significands of a floating-point addition and rounds the sum to nearest-even in the same step. It does not add first and then run a separate incrementer. A carry-select compound adder produces the plain sum and the sum plus one in parallel. A small decision stage then looks at the overflow bit, the low bits of the sum and the guard, round and sticky bits of the shifted operand, and selects one of the two candidates.

The operand `op_a` is the significand of the operand with the larger exponent, with its hidden bit set. The operand `op_b` is the aligned significand of the smaller operand. The three tail inputs are the bits that alignment shifted out of `op_b`; the sticky input is already the OR of everything below the round bit.

When the sum carries into a new top bit, the result is shifted right by one. Rounding then injects its 1 at the old least significant bit, which now serves as the guard position. The carry from that position reaches the new least significant bit, so the sum-plus-one candidate is still the correct one.

Outputs are the normalized, rounded significand, a flag telling the exponent logic to add one, and an inexact flag. All three are registered one clock after the inputs.

Top module: `sig_round_add`

## Requirements
- R1: When the sum does not overflow and no rounding up occurs, `sig_out` equals the low SIG_W bits of `op_a + op_b` and `exp_inc` is 0.
- R2: Without overflow, the result rounds up to `op_a + op_b + 1` exactly when the guard bit is 1 and at least one of round, sticky or the sum's LSB is 1.
- R3: When the discarded part is exactly half an LSB (guard 1, all lower discarded bits 0), the result is the candidate whose LSB is 0.
- R4: When `op_a + op_b` is at least 2^SIG_W, `sig_out` is the sum shifted right by one and rounded to nearest-even. The shifted-out sum bit acts as the guard, and guard, round and sticky together act as the sticky bit. `exp_inc` is 1.
- R5: When rounding up carries out of the top bit, `sig_out` is 1 followed by zeros and `exp_inc` is 1.
- R6: `inexact` is 1 exactly when any bit discarded by normalization or by the tail inputs is nonzero.
- R7: Whenever the MSB of `op_a` is 1, the MSB of `sig_out` is 1.
- R8: Outputs update on the rising clock edge one cycle after the inputs, and a synchronous active-high reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | SIG_W | Significand of the larger operand, hidden bit included |
| op_b | input | SIG_W | Aligned significand of the smaller operand |
| guard_in | input | 1 | First bit shifted out of op_b |
| round_in | input | 1 | Second bit shifted out of op_b |
| sticky_in | input | 1 | OR of all further bits shifted out of op_b |
| sig_out | output | SIG_W | Rounded, normalized significand |
| exp_inc | output | 1 | Exponent must be incremented by one |
| inexact | output | 1 | Result differs from the exact sum |

## Verification
The normalization assertion assumes that `op_a` carries its hidden bit. It also assumes that the tail bits describe only the shifted operand, so that the larger operand contributes nothing below the LSB. The sweep therefore runs `op_a` only over values with the top bit set. `op_b` runs over every value, and all eight tail combinations are applied. Each vector is held stable across one full clock so that the registered result pairs with the inputs that produced it.

// File: rtl/sig_round_pkg.sv
package sig_round_pkg;
  typedef struct packed {
    logic g;
    logic r;
    logic s;
  } tail_t;
endpackage

// File: rtl/cmpd_adder.sv
module cmpd_adder #(
  parameter int SIG_W = 24,
  parameter int BLK_W = 4
) (
  input  logic [SIG_W-1:0] a,
  input  logic [SIG_W-1:0] b,
  output logic [SIG_W:0]   sum0,
  output logic [SIG_W:0]   sum1
);
  localparam int NB = (SIG_W + BLK_W - 1) / BLK_W;
  localparam int PW = NB * BLK_W;

  logic [PW-1:0] pa, pb;
  logic [PW-1:0] w_lo, w_hi;
  logic [NB:0]   c_lo, c_hi;
  logic [PW:0]   f_lo, f_hi;

  assign pa = PW'(a);
  assign pb = PW'(b);
  assign c_lo[0] = 1'b0;
  assign c_hi[0] = 1'b1;

  // each block precomputes both carry-in outcomes; two select chains pick
  for (genvar k = 0; k < NB; k++) begin : g_blk
    logic [BLK_W:0] t0, t1;
    assign t0 = {1'b0, pa[k*BLK_W +: BLK_W]} + {1'b0, pb[k*BLK_W +: BLK_W]};
    assign t1 = {1'b0, pa[k*BLK_W +: BLK_W]} + {1'b0, pb[k*BLK_W +: BLK_W]}
                + (BLK_W+1)'(1);
    assign w_lo[k*BLK_W +: BLK_W] = c_lo[k] ? t1[BLK_W-1:0] : t0[BLK_W-1:0];
    assign w_hi[k*BLK_W +: BLK_W] = c_hi[k] ? t1[BLK_W-1:0] : t0[BLK_W-1:0];
    assign c_lo[k+1] = c_lo[k] ? t1[BLK_W] : t0[BLK_W];
    assign c_hi[k+1] = c_hi[k] ? t1[BLK_W] : t0[BLK_W];
  end

  assign f_lo = {c_lo[NB], w_lo};
  assign f_hi = {c_hi[NB], w_hi};
  assign sum0 = f_lo[SIG_W:0];
  assign sum1 = f_hi[SIG_W:0];
endmodule

// File: rtl/round_sel.sv
module round_sel
  import sig_round_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W:0]   sum0,
  input  logic [SIG_W:0]   sum1,
  input  tail_t            tail,
  output logic [SIG_W-1:0] sig,
  output logic             exp_inc,
  output logic             inexact
);
  logic ovf, lsb, grd, stk, up;
  logic [SIG_W:0] pick;

  always_comb begin
    ovf  = sum0[SIG_W];
    // on overflow the result LSB moves up one place
    lsb  = ovf ? sum0[1] : sum0[0];
    grd  = ovf ? sum0[0] : tail.g;
    stk  = ovf ? (tail.g | tail.r | tail.s) : (tail.r | tail.s);
    up   = grd & (stk | lsb);
    // overflow + up implies sum0[0]=1, so sum1 carries into bit 1
    pick = up ? sum1 : sum0;
    if (pick[SIG_W]) sig = pick[SIG_W:1];
    else             sig = pick[SIG_W-1:0];
    exp_inc = pick[SIG_W];
    inexact = grd | stk;
  end
endmodule

// File: rtl/sig_round_add.sv
module sig_round_add
  import sig_round_pkg::*;
#(
  parameter int SIG_W = 24,
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SIG_W-1:0] op_a,
  input  logic [SIG_W-1:0] op_b,
  input  logic             guard_in,
  input  logic             round_in,
  input  logic             sticky_in,
  output logic [SIG_W-1:0] sig_out,
  output logic             exp_inc,
  output logic             inexact
);
  logic [SIG_W:0]   sum0, sum1;
  logic [SIG_W-1:0] sig_c;
  logic             inc_c, inx_c;
  tail_t            tail;

  assign tail = '{g: guard_in, r: round_in, s: sticky_in};

  cmpd_adder #(.SIG_W(SIG_W), .BLK_W(BLK_W)) u_add (
    .a(op_a), .b(op_b), .sum0(sum0), .sum1(sum1)
  );

  round_sel #(.SIG_W(SIG_W)) u_sel (
    .sum0(sum0), .sum1(sum1), .tail(tail),
    .sig(sig_c), .exp_inc(inc_c), .inexact(inx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_out <= '0;
      exp_inc <= 1'b0;
      inexact <= 1'b0;
    end else begin
      sig_out <= sig_c;
      exp_inc <= inc_c;
      inexact <= inx_c;
    end
  end

  AST_CANDIDATE_STEP: assert property (@(posedge clk) disable iff (rst)
    sum1 == sum0 + (SIG_W+1)'(1)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (sig_out == '0 && !exp_inc && !inexact)); // R8

  AST_INEXACT_SEEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(guard_in | round_in | sticky_in)) |-> inexact); // R6

  AST_NORM_MSB: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_a[SIG_W-1])) |-> sig_out[SIG_W-1]); // R7

  AST_EXACT_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(guard_in | round_in | sticky_in) && !$past(sum0[SIG_W]))
    |-> (sig_out == $past(sum0[SIG_W-1:0]) && !exp_inc)); // R1

  AST_OVF_INC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sum0[SIG_W])) |-> exp_inc); // R4
endmodule

// File: tb/test_sig_round_add.sv
`timescale 1ns/1ps
module test_sig_round_add;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         g_in = 1'b0, r_in = 1'b0, s_in = 1'b0;
  logic [W-1:0] sig_out;
  logic         exp_inc, inexact;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  sig_round_add #(.SIG_W(W), .BLK_W(4)) i_sig_round_add (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .guard_in(g_in), .round_in(r_in), .sticky_in(s_in),
    .sig_out(sig_out), .exp_inc(exp_inc), .inexact(inexact)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d t=%0d%0d%0d actual=%0h expected=%0h",
               tag, op_a, op_b, g_in, r_in, s_in, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: reset clears outputs even with active inputs
    @(negedge clk);
    op_a = 6'h3f; op_b = 6'h3f; g_in = 1; r_in = 1; s_in = 1;
    @(posedge clk); #1;
    chk("R8 reset", {sig_out, exp_inc, inexact}, 0);
    @(negedge clk); rst = 0;
    op_a = 6'h20; op_b = 6'h01; g_in = 0; r_in = 0; s_in = 0;
    #1;
    chk("R8 latency hold", {sig_out, exp_inc, inexact}, 0);
    @(posedge clk); #1;
    chk("R8 latency update", sig_out, 6'h21);

    for (int a = 2**(W-1); a < 2**W; a++) begin
      for (int b = 0; b < 2**W; b++) begin
        for (int t = 0; t < 8; t++) begin
          int s, num, half, mant, em;
          bit ovf, rup, carry, einc;
          string tag;
          @(negedge clk);
          op_a = W'(a); op_b = W'(b);
          g_in = t[2]; r_in = t[1]; s_in = t[0];
          s   = a + b;
          ovf = (s >= 2**W);
          if (ovf) begin num = (s % 2) * 8 + t; half = 8; mant = s / 2; end
          else     begin num = t;               half = 4; mant = s;     end
          rup   = (num > half) || (num == half && (mant % 2) == 1);
          em    = mant + (rup ? 1 : 0);
          carry = (em == 2**W);
          if (carry) em = 2**(W-1);
          einc  = ovf || carry;
          if (carry)            tag = "R5 carry-out";
          else if (ovf)         tag = "R4 overflow";
          else if (num == half) tag = "R3 tie";
          else if (rup)         tag = "R2 round-up";
          else                  tag = "R1 pass";
          @(posedge clk); #1;
          chk(tag, {sig_out, exp_inc}, {em[W-1:0], einc});
          chk("R6 inexact", inexact, (num != 0) ? 1 : 0);
          chk("R7 msb", sig_out[W-1], 1);
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule